// File: doc/BRIEF.md
# Multi-Round Priority Interrupt Arbiter

This block chooses which of several interrupt sources should be served next. Every source has three things: a fixed priority value, an enable bit and a pending-request flag. A pending flag is set by a pulse on that source's hardware event line or by a software write that names the source. It stays set until a software clear write names that source. The arbiter repeatedly runs an arbitration. Each arbitration is a fixed chain of rounds. Each round looks at one 2-bit slice of the priority, starting with the most significant slice in use. In each round, every source whose slice is below the largest slice among the remaining candidates drops out.

The round count can be set from 1 to 4, and each round takes either one or two clock cycles. The time for one arbitration is therefore fixed, and software can pad for it. With fewer rounds, only the low bits of each priority take part, which suits systems with a smaller priority range. At the end of every arbitration the block raises a one-cycle done strobe. It raises the winner-valid flag at the same time, together with the winning priority and source index, when some source won. Request writes are taken at any time. Each arbitration works on the candidates captured in its first cycle.

Top module: `multi_round_arb`

## Requirements
- R1: A pulse on `hw_evt[i]`, or `sw_set` with `sw_idx` = i, sets the request flag of source i at the next clock edge. A set and a clear of the same source in the same cycle leave the flag set.
- R2: `sw_clr` with `sw_idx` = i clears the request flag of source i at the next clock edge. The source then stops winning.
- R3: A source competes only when its request flag is set, its `src_en` bit is 1 and its compared priority bits are not all zero. A source with compared priority 0 never wins.
- R4: Among the competing sources, the one with the largest compared priority wins. `win_idx` gives its source number and `win_prio` gives its compared priority value. Priorities are assumed unique.
- R5: One arbitration lasts `cfg_rounds` × (`cfg_two_cycle` ? 2 : 1) cycles. Values of `cfg_rounds` below 1 are taken as 1, and values above 4 are taken as 4. `arb_done` pulses for one cycle at the end of every arbitration, and `win_valid` is high only together with `arb_done`.
- R6: An arbitration uses the candidate set present in its first cycle. A request that changes during an arbitration does not affect that arbitration's result. It is reflected no later than the end of the following arbitration.
- R7: With R rounds, only priority bits [2R-1:0] are compared, two bits per round, most significant slice first. Higher bits are ignored, and `win_prio` reports the compared bits with the upper bits at zero.
- R8: While reset is active, `arb_done`, `win_valid`, `win_prio` and `win_idx` are all 0, and all request flags are cleared.
- R9: An arbitration with no competing source pulses `arb_done` with `win_valid` low. In that case `win_prio` and `win_idx` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_prio | input | N_SRC*PRIO_W | Static priority of every source, source i in bits [i*PRIO_W +: PRIO_W] |
| src_en | input | N_SRC | Per-source enable |
| hw_evt | input | N_SRC | Per-source hardware request pulse |
| sw_set | input | 1 | Software set strobe for source `sw_idx` |
| sw_clr | input | 1 | Software clear strobe for source `sw_idx` |
| sw_idx | input | IDX_W | Source addressed by the software strobes |
| cfg_rounds | input | CFG_W | Number of arbitration rounds (1..4) |
| cfg_two_cycle | input | 1 | 1: each round lasts two cycles; 0: one cycle |
| arb_done | output | 1 | One-cycle strobe at the end of each arbitration |
| win_valid | output | 1 | A winner was found in the arbitration just ended |
| win_prio | output | PRIO_W | Compared priority of the last winner |
| win_idx | output | IDX_W | Source number of the last winner |

## Verification
Some properties are checked by assertions on every cycle:
- The spacing between done strobes, which must equal the configured arbitration length.
- That `win_valid` never appears without `arb_done`.
- That a reported winner never has priority zero.
- That the candidate set only shrinks within an arbitration and never empties while candidates remain.
- That the request flags respond to set and clear strobes.

Other behaviour only the bench scenarios can show:
- That the right source wins across the different round settings.
- That disabled sources and sources with zero priority are passed over.
- That a request arriving mid-arbitration is held back until the next arbitration.
- That the outputs keep their old values when nothing is pending.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Round count actually used, clamped into the legal range.
  function automatic int clamp_rounds(input int asked, input int max_r);
    if (asked < 1) return 1;
    if (asked > max_r) return max_r;
    return asked;
  endfunction

  // Cycles spent by one complete arbitration.
  function automatic int arb_len(input int rounds, input logic two_cyc);
    return two_cyc ? 2 * rounds : rounds;
  endfunction

endpackage

// File: rtl/arb_req_bank.sv
module arb_req_bank #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] hw_evt,
  input  logic             sw_set,
  input  logic             sw_clr,
  input  logic [IDX_W-1:0] sw_idx,
  output logic [N_SRC-1:0] req
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    logic hit_set, hit_clr;
    assign hit_set = hw_evt[i] | (sw_set & (sw_idx == IDX_W'(i)));
    assign hit_clr = sw_clr & (sw_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)       req[i] <= 1'b0;
      else if (hit_set) req[i] <= 1'b1;
      else if (hit_clr) req[i] <= 1'b0;
    end

    // R1: a hardware pulse always leaves the flag set
    assert_hw_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hw_evt[i] |=> req[i]);
    // R1: a software set write always leaves the flag set
    assert_sw_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_set && sw_idx == IDX_W'(i)) |=> req[i]);
    // R2: a lone clear write drops the flag
    assert_sw_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr && sw_idx == IDX_W'(i) && !hw_evt[i] && !(sw_set && sw_idx == IDX_W'(i)))
      |=> !req[i]);
  end

endmodule

// File: rtl/arb_round_filter.sv
module arb_round_filter #(
  parameter int N_SRC   = 8,
  parameter int PRIO_W  = 8,
  parameter int SLICE_W = 2,
  parameter int RND_W   = 2
) (
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  input  logic [N_SRC-1:0]        in_mask,
  input  logic [RND_W-1:0]        slot,
  output logic [N_SRC-1:0]        out_mask
);

  localparam int NV = 2 ** SLICE_W;

  logic [SLICE_W-1:0] sl [N_SRC];
  logic [NV-1:1]      present;
  logic [SLICE_W-1:0] top_val;

  always_comb begin
    for (int i = 0; i < N_SRC; i++)
      sl[i] = prio_flat[i*PRIO_W + int'(slot)*SLICE_W +: SLICE_W];
  end

  always_comb begin
    present = '0;
    for (int v = 1; v < NV; v++)
      for (int i = 0; i < N_SRC; i++)
        if (in_mask[i] && sl[i] == SLICE_W'(v)) present[v] = 1'b1;
  end

  always_comb begin
    top_val = '0;
    for (int v = 1; v < NV; v++)
      if (present[v]) top_val = SLICE_W'(v);
  end

  always_comb begin
    for (int i = 0; i < N_SRC; i++)
      out_mask[i] = in_mask[i] && (sl[i] == top_val);
  end

endmodule

// File: rtl/arb_round_seq.sv
module arb_round_seq #(
  parameter int RND_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RND_W-1:0] last_rnd,
  input  logic             two_cycle,
  output logic [RND_W-1:0] slot,
  output logic             step_first,
  output logic             step_last_sub,
  output logic             step_end
);

  logic [RND_W-1:0] rnd;
  logic             sub;

  assign step_first    = (rnd == '0) && !sub;
  assign step_last_sub = !two_cycle || sub;
  assign step_end      = step_last_sub && (rnd >= last_rnd);
  assign slot          = last_rnd - rnd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rnd <= '0;
      sub <= 1'b0;
    end else if (step_last_sub) begin
      sub <= 1'b0;
      rnd <= step_end ? '0 : rnd + 1'b1;
    end else begin
      sub <= 1'b1;
    end
  end

  // R5: the round counter stays within the configured round count
  assert_rnd_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(last_rnd) |-> rnd <= last_rnd);
  // R5: a two-cycle round never skips its second cycle
  assert_two_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (two_cycle && !sub) |-> !step_end);

endmodule

// File: rtl/multi_round_arb.sv
module multi_round_arb
  import arb_pkg::*;
#(
  parameter int N_SRC   = 8,
  parameter int PRIO_W  = 8,
  parameter int SLICE_W = 2,
  localparam int MAX_ROUNDS = PRIO_W / SLICE_W,
  localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int RND_W  = (MAX_ROUNDS > 1) ? $clog2(MAX_ROUNDS) : 1,
  localparam int CFG_W  = RND_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC*PRIO_W-1:0] src_prio,
  input  logic [N_SRC-1:0]        src_en,
  input  logic [N_SRC-1:0]        hw_evt,
  input  logic                    sw_set,
  input  logic                    sw_clr,
  input  logic [IDX_W-1:0]        sw_idx,
  input  logic [CFG_W-1:0]        cfg_rounds,
  input  logic                    cfg_two_cycle,
  output logic                    arb_done,
  output logic                    win_valid,
  output logic [PRIO_W-1:0]       win_prio,
  output logic [IDX_W-1:0]        win_idx
);

  int                    rounds_i;
  logic [RND_W-1:0]      last_rnd;
  logic [N_SRC*PRIO_W-1:0] mprio;
  logic [N_SRC-1:0]      req, cand, alive, eff_mask, filt, alive_next;
  logic [RND_W-1:0]      slot;
  logic                  step_first, step_last_sub, step_end;
  logic [IDX_W-1:0]      sel_idx;
  logic [PRIO_W-1:0]     sel_prio;

  always_comb rounds_i = clamp_rounds(int'(cfg_rounds), MAX_ROUNDS);
  assign last_rnd = RND_W'(rounds_i - 1);

  // Keep only the priority bits that the configured rounds cover.
  always_comb begin
    for (int i = 0; i < N_SRC; i++)
      for (int b = 0; b < PRIO_W; b++)
        mprio[i*PRIO_W + b] = src_prio[i*PRIO_W + b] & (b < rounds_i * SLICE_W);
  end

  always_comb begin
    for (int i = 0; i < N_SRC; i++)
      cand[i] = req[i] & src_en[i] & (|mprio[i*PRIO_W +: PRIO_W]);
  end

  arb_req_bank #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_req (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .sw_set(sw_set),
    .sw_clr(sw_clr), .sw_idx(sw_idx), .req(req)
  );

  arb_round_seq #(.RND_W(RND_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .last_rnd(last_rnd), .two_cycle(cfg_two_cycle),
    .slot(slot), .step_first(step_first), .step_last_sub(step_last_sub),
    .step_end(step_end)
  );

  assign eff_mask = step_first ? cand : alive;

  arb_round_filter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .SLICE_W(SLICE_W), .RND_W(RND_W)) u_filt (
    .prio_flat(mprio), .in_mask(eff_mask), .slot(slot), .out_mask(filt)
  );

  assign alive_next = step_last_sub ? filt : eff_mask;

  always_comb begin
    sel_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (filt[i]) sel_idx = IDX_W'(i);
  end
  assign sel_prio = mprio[int'(sel_idx)*PRIO_W +: PRIO_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alive     <= '0;
      arb_done  <= 1'b0;
      win_valid <= 1'b0;
      win_prio  <= '0;
      win_idx   <= '0;
    end else begin
      alive    <= alive_next;
      arb_done <= step_end;
      win_valid <= step_end && (|filt);
      if (step_end && (|filt)) begin
        win_prio <= sel_prio;
        win_idx  <= sel_idx;
      end
    end
  end

  // Cycles since reset or since the last done strobe, for the period check.
  logic [7:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n)        gap <= '0;
    else if (arb_done) gap <= 8'd1;
    else if (gap != 8'hFF) gap <= gap + 8'd1;
  end

  // R5: done strobes are spaced exactly one arbitration apart
  assert_done_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arb_done |-> gap == 8'(arb_len(rounds_i, cfg_two_cycle)));
  // R5: a winner is reported only together with the done strobe
  assert_valid_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> arb_done);
  // R3: a reported winner never has priority zero
  assert_winner_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> win_prio != '0);
  // R4: past the first step, the candidate set can only shrink
  assert_alive_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !step_first |-> (alive_next & ~alive) == '0);
  // R4: a round never discards every remaining candidate
  assert_round_keeps_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_last_sub && (|eff_mask)) |-> (|filt));
  // R4: with unique priorities the final round leaves at most one source
  assert_single_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_end |-> $onehot0(filt));

endmodule

// File: tb/tb_multi_round_arb.sv
module tb_multi_round_arb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int PW = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*PW-1:0] src_prio;
  logic [N-1:0] src_en = '1;
  logic [N-1:0] hw_evt = '0;
  logic sw_set = 1'b0, sw_clr = 1'b0;
  logic [IW-1:0] sw_idx = '0;
  logic [2:0] cfg_rounds = 3'd4;
  logic cfg_two_cycle = 1'b0;
  logic arb_done, win_valid;
  logic [PW-1:0] win_prio;
  logic [IW-1:0] win_idx;

  multi_round_arb #(.N_SRC(N), .PRIO_W(PW), .SLICE_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .src_prio(src_prio), .src_en(src_en), .hw_evt(hw_evt),
    .sw_set(sw_set), .sw_clr(sw_clr), .sw_idx(sw_idx), .cfg_rounds(cfg_rounds),
    .cfg_two_cycle(cfg_two_cycle), .arb_done(arb_done), .win_valid(win_valid),
    .win_prio(win_prio), .win_idx(win_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // source:        7     6     5     4     3     2     1     0
  assign src_prio = {8'h31, 8'h7E, 8'h00, 8'h02, 8'hC1, 8'h40, 8'h13, 8'h05};

  typedef struct {
    logic       v;
    logic [7:0] p;
    logic [2:0] i;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;

  task automatic check_val(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every done strobe consumes one expected item, if any.
  always @(negedge clk) begin
    if (rst_n && arb_done && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check_val({e.tag, " valid"}, int'(win_valid), int'(e.v));
      check_val({e.tag, " prio"},  int'(win_prio),  int'(e.p));
      check_val({e.tag, " idx"},   int'(win_idx),   int'(e.i));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!arb_done);
  endtask

  task automatic push_exp(input logic v, input logic [7:0] p, input logic [2:0] i, input string tag);
    exp_t e;
    e.v = v; e.p = p; e.i = i; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  // After a change: let the in-flight arbitration end, then expect the next one.
  task automatic expect_next(input logic v, input logic [7:0] p, input logic [2:0] i, input string tag);
    wait_done();
    #1;
    push_exp(v, p, i, tag);
    drain();
  endtask

  task automatic sw_write(input bit set, input int idx);
    sw_idx = IW'(idx);
    if (set) sw_set = 1'b1; else sw_clr = 1'b1;
    @(negedge clk);
    sw_set = 1'b0;
    sw_clr = 1'b0;
  endtask

  task automatic hw_pulse(input int idx);
    hw_evt[idx] = 1'b1;
    @(negedge clk);
    hw_evt = '0;
  endtask

  task automatic do_reset(input logic [2:0] rounds, input logic two);
    rst_n = 1'b0;
    cfg_rounds = rounds;
    cfg_two_cycle = two;
    src_en = '1;
    tick(3);
    rst_n = 1'b1;
  endtask

  task automatic check_period(input int exp_len, input string tag);
    int cnt;
    wait_done();
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!arb_done);
    check_val(tag, cnt, exp_len);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // ---- Four rounds, one cycle each ----
    rst_n = 1'b0;
    tick(3);
    check_val("R8 reset done",  int'(arb_done),  0);
    check_val("R8 reset valid", int'(win_valid), 0);
    check_val("R8 reset prio",  int'(win_prio),  0);
    check_val("R8 reset idx",   int'(win_idx),   0);
    do_reset(3'd4, 1'b0);

    check_period(4, "R5 period 4x1");
    expect_next(1'b0, 8'h00, 3'd0, "R9 no request");

    hw_pulse(2);
    expect_next(1'b1, 8'h40, 3'd2, "R1 hw set");
    sw_write(1, 6);
    expect_next(1'b1, 8'h7E, 3'd6, "R4 higher wins");
    sw_write(1, 3);
    expect_next(1'b1, 8'hC1, 3'd3, "R4 top slice");
    src_en[3] = 1'b0;
    expect_next(1'b1, 8'h7E, 3'd6, "R3 disabled skipped");

    sw_write(0, 6);
    sw_write(0, 2);
    sw_write(1, 5);
    expect_next(1'b0, 8'h7E, 3'd6, "R3 zero prio / R9 hold");
    src_en[3] = 1'b1;
    expect_next(1'b1, 8'hC1, 3'd3, "R3 re-enabled pending");
    sw_write(0, 3);
    expect_next(1'b0, 8'hC1, 3'd3, "R2 clear");

    // Set and clear of the same source in one cycle: set wins.
    hw_evt[4] = 1'b1;
    sw_idx = 3'd4;
    sw_clr = 1'b1;
    @(negedge clk);
    hw_evt = '0;
    sw_clr = 1'b0;
    expect_next(1'b1, 8'h02, 3'd4, "R1 set beats clear");

    // Request raised after an arbitration took its snapshot.
    wait_done();
    tick(1);
    sw_idx = 3'd7;
    sw_set = 1'b1;
    push_exp(1'b1, 8'h02, 3'd4, "R6 in-flight unchanged");
    @(negedge clk);
    sw_set = 1'b0;
    drain();
    push_exp(1'b1, 8'h31, 3'd7, "R6 next arbitration");
    drain();

    // ---- Three rounds, two cycles each ----
    do_reset(3'd3, 1'b1);
    check_period(6, "R5 period 3x2");
    sw_write(1, 1);
    sw_write(1, 3);
    sw_write(1, 6);
    expect_next(1'b1, 8'h3E, 3'd6, "R7 six bits");
    sw_write(0, 6);
    expect_next(1'b1, 8'h13, 3'd1, "R7 upper bits dropped");

    // ---- Two rounds, one cycle each ----
    do_reset(3'd2, 1'b0);
    check_period(2, "R5 period 2x1");
    sw_write(1, 0);
    sw_write(1, 1);
    sw_write(1, 2);
    expect_next(1'b1, 8'h05, 3'd0, "R7 four bits");
    sw_write(0, 0);
    expect_next(1'b1, 8'h03, 3'd1, "R7 masked value");
    sw_write(0, 1);
    expect_next(1'b0, 8'h03, 3'd1, "R7 masked to zero");

    // ---- Out-of-range round count clamps to four ----
    do_reset(3'd7, 1'b0);
    check_period(4, "R5 clamp");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule